// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block sits between a CPU that signals an interrupt acknowledge machine cycle only through its opcode-fetch line (M1) and peripherals that expect a dedicated acknowledge strobe followed later by a read strobe. The acknowledge cycle is told apart from an opcode fetch early. M1 is active while memory request is inactive, and this is sampled at a rising edge of the peripheral clock. From that edge a shift register counts peripheral clocks. The acknowledge strobe is driven from the first stage. The read strobe comes from a later tap, so the daisy chain has time to settle. Wait to the CPU is released from a still later tap, once the vector is valid on the bus.

All strobes are active low. Each one is merged with the system read, write and wait by an AND, so ordinary memory and I/O cycles stay under the control of other logic. While M1 is inactive, the register is held cleared. An active-low reset drives read and write active together, which the peripherals take as their own reset. If the CPU and the peripheral run on different clocks, a synchronizing stage can be selected. It adds one peripheral clock before the acknowledge strobe, and all later delays are counted from there. Legacy peripherals on the same chain see an I/O request that is held back until the read tap fires.

Top module: `iack_sequencer`

## Requirements
- R1: While m1_ni is high, the sequencer is cleared at every clock edge. intack_no is high, and rd_no, wr_no, wait_no and legacy_iorq_no follow sys_rd_ni, sys_wr_ni, sys_wait_ni and iorq_ni.
- R2: An opcode fetch (m1_ni low and mreq_ni low) never asserts intack_no.
- R3: With SYNC_EN=0, intack_no goes low at the first rising edge that samples m1_ni low with mreq_ni high. It stays low until an edge samples m1_ni high.
- R4: rd_no goes low exactly RD_TAP clocks after intack_no goes low, and stays low until the acknowledge ends.
- R5: wait_no is low from the edge at which intack_no falls, for exactly WAIT_TAP clocks. After that it follows sys_wait_ni.
- R6: Each active-low output is the AND of the system signal and the sequencer strobe, so a low on sys_rd_ni, sys_wr_ni or sys_wait_ni always reaches the output.
- R7: While rst_ni is low, rd_no and wr_no are both low and the sequencer is cleared.
- R8: With SYNC_EN=1, every sequencer strobe is delayed by exactly one clock compared with SYNC_EN=0.
- R9: During an acknowledge, legacy_iorq_no is held high until the read tap fires, and then follows iorq_ni. Outside an acknowledge it equals iorq_ni.
- R10: With a 250 ns peripheral clock and the default taps (RD_TAP=2, WAIT_TAP=4), the acknowledge-to-read time is at least 350 ns. Read is also held at least 350 ns before wait is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m1_ni | input | 1 | CPU opcode-fetch / acknowledge line, active low |
| mreq_ni | input | 1 | CPU memory request, active low |
| iorq_ni | input | 1 | CPU I/O request, active low |
| sys_rd_ni | input | 1 | System read from other logic, active low |
| sys_wr_ni | input | 1 | System write from other logic, active low |
| sys_wait_ni | input | 1 | System wait from other logic, active low |
| intack_no | output | 1 | Interrupt acknowledge to peripherals, active low |
| rd_no | output | 1 | Merged read to peripherals, active low |
| wr_no | output | 1 | Merged write to peripherals, active low |
| wait_no | output | 1 | Merged wait to the CPU, active low |
| legacy_iorq_no | output | 1 | Delayed I/O request to legacy peripherals, active low |

## Verification
The hardest case to reach is the acknowledge whose read and wait taps are observed at their exact clocks. The synchronized variant must at the same time lag by exactly one clock. The bench drives both variants from the same pins. It holds M1 low with memory request high for longer than the deepest tap, and lets I/O request fall partway through. A behavioural count of qualifying edges then predicts every strobe on every clock. Reset is also asserted in the middle of an acknowledge, and an opcode fetch is placed directly before one, to show that nothing stale is carried forward.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam int unsigned DEF_RD_TAP   = 2;
  localparam int unsigned DEF_WAIT_TAP = 4;

  typedef struct packed {
    logic ack;   // acknowledge stage active
    logic rd;    // read tap reached
    logic hold;  // cpu must wait
  } iack_strobe_t;
endpackage

// File: rtl/iack_sync.sv
module iack_sync #(
  parameter bit EN = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  generate
    if (EN) begin : g_flop
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q_q <= 1'b0;
        else if (clr_i) q_q <= 1'b0;
        else            q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_bypass
      logic unused_sync;
      assign unused_sync = ^{clk_i, rst_ni, clr_i};
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/iack_shifter.sv
module iack_shifter #(
  parameter int unsigned RD_TAP   = iack_pkg::DEF_RD_TAP,
  parameter int unsigned WAIT_TAP = iack_pkg::DEF_WAIT_TAP
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output iack_pkg::iack_strobe_t strobe_o
);
  localparam int unsigned DEPTH = WAIT_TAP + 1;

  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stage_q <= '0;
    else if (clr_i) stage_q <= '0;
    else            stage_q <= {stage_q[DEPTH-2:0], d_i};
  end

  always_comb begin
    strobe_o.ack  = stage_q[0];
    strobe_o.rd   = stage_q[RD_TAP];
    strobe_o.hold = stage_q[0] & ~stage_q[WAIT_TAP];
  end
endmodule

// File: rtl/iack_merge.sv
module iack_merge (
  input  logic                  rst_ni,
  input  logic                  m1_ni,
  input  logic                  iorq_ni,
  input  logic                  sys_rd_ni,
  input  logic                  sys_wr_ni,
  input  logic                  sys_wait_ni,
  input  iack_pkg::iack_strobe_t strobe_i,
  output logic                  intack_no,
  output logic                  rd_no,
  output logic                  wr_no,
  output logic                  wait_no,
  output logic                  legacy_iorq_no
);
  always_comb begin
    intack_no      = ~strobe_i.ack;
    // reset forces read and write low together
    rd_no          = rst_ni & sys_rd_ni & ~strobe_i.rd;
    wr_no          = rst_ni & sys_wr_ni;
    wait_no        = sys_wait_ni & ~strobe_i.hold;
    legacy_iorq_no = iorq_ni | (~m1_ni & ~strobe_i.rd);
  end
endmodule

// File: rtl/iack_sequencer.sv
module iack_sequencer #(
  parameter bit          SYNC_EN  = 1'b0,
  parameter int unsigned RD_TAP   = iack_pkg::DEF_RD_TAP,
  parameter int unsigned WAIT_TAP = iack_pkg::DEF_WAIT_TAP
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic m1_ni,
  input  logic mreq_ni,
  input  logic iorq_ni,
  input  logic sys_rd_ni,
  input  logic sys_wr_ni,
  input  logic sys_wait_ni,
  output logic intack_no,
  output logic rd_no,
  output logic wr_no,
  output logic wait_no,
  output logic legacy_iorq_no
);
  logic detect, shift_in;
  iack_pkg::iack_strobe_t strobe;

  // acknowledge: M1 active without memory request
  assign detect = ~m1_ni & mreq_ni;

  iack_sync #(.EN(SYNC_EN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (m1_ni),
    .d_i   (detect),
    .q_o   (shift_in)
  );

  iack_shifter #(.RD_TAP(RD_TAP), .WAIT_TAP(WAIT_TAP)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (m1_ni),
    .d_i     (shift_in),
    .strobe_o(strobe)
  );

  iack_merge u_merge (
    .rst_ni        (rst_ni),
    .m1_ni         (m1_ni),
    .iorq_ni       (iorq_ni),
    .sys_rd_ni     (sys_rd_ni),
    .sys_wr_ni     (sys_wr_ni),
    .sys_wait_ni   (sys_wait_ni),
    .strobe_i      (strobe),
    .intack_no     (intack_no),
    .rd_no         (rd_no),
    .wr_no         (wr_no),
    .wait_no       (wait_no),
    .legacy_iorq_no(legacy_iorq_no)
  );
endmodule

// File: rtl/iack_sequencer_chk.sv
module iack_sequencer_chk #(
  parameter int unsigned RD_TAP   = iack_pkg::DEF_RD_TAP,
  parameter int unsigned WAIT_TAP = iack_pkg::DEF_WAIT_TAP
) (
  input logic clk_i,
  input logic rst_ni,
  input logic m1_ni,
  input logic mreq_ni,
  input logic iorq_ni,
  input logic sys_rd_ni,
  input logic sys_wr_ni,
  input logic sys_wait_ni,
  input logic intack_no,
  input logic rd_no,
  input logic wr_no,
  input logic wait_no,
  input logic legacy_iorq_no
);
  logic [7:0] ack_cnt;
  logic       rd_seq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ack_cnt <= '0;
    else if (intack_no)        ack_cnt <= '0;
    else if (ack_cnt != 8'hff) ack_cnt <= ack_cnt + 8'd1;
  end

  assign rd_seq = sys_rd_ni & ~rd_no;

  assert_m1_idle_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m1_ni |=> intack_no);

  assert_fetch_no_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1_ni && !mreq_ni && intack_no) |=> intack_no);

  assert_rd_after_tap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_seq |-> (!intack_no && ack_cnt >= RD_TAP));

  assert_rd_at_tap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1_ni && !intack_no && ack_cnt >= RD_TAP) |-> !rd_no);

  assert_wait_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!intack_no && ack_cnt < WAIT_TAP) |-> !wait_no);

  assert_wait_released_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!intack_no && ack_cnt >= WAIT_TAP) |-> (wait_no == sys_wait_ni));

  assert_wait_only_in_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_wait_ni && !wait_no) |-> !intack_no);

  assert_wr_passthru_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_no == sys_wr_ni);

  assert_legacy_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1_ni && !intack_no && ack_cnt < RD_TAP) |-> legacy_iorq_no);

  assert_legacy_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m1_ni |-> (legacy_iorq_no == iorq_ni));

  always_comb begin
    if (rst_ni === 1'b0) begin
      assert_reset_rdwr_R7: assert (rd_no === 1'b0 && wr_no === 1'b0);
    end
  end
endmodule

bind iack_sequencer iack_sequencer_chk #(.RD_TAP(RD_TAP), .WAIT_TAP(WAIT_TAP)) u_chk (.*);

// File: tb/iack_sequencer_bench.sv
`timescale 1ns/1ps
module iack_sequencer_bench;
  localparam int CLK_PERIOD = 250;
  localparam int RD_TAP     = 2;
  localparam int WAIT_TAP   = 4;
  localparam int MIN_NS     = 350;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m1_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1;
  logic srd_n = 1'b1, swr_n = 1'b1, swait_n = 1'b1;
  logic [1:0] intack, rd, wr, wt, liorq;

  int checks = 0;
  int fails  = 0;
  int run    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iack_sequencer #(.SYNC_EN(1'b0), .RD_TAP(RD_TAP), .WAIT_TAP(WAIT_TAP)) u_iack_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .m1_ni(m1_n), .mreq_ni(mreq_n), .iorq_ni(iorq_n),
    .sys_rd_ni(srd_n), .sys_wr_ni(swr_n), .sys_wait_ni(swait_n),
    .intack_no(intack[0]), .rd_no(rd[0]), .wr_no(wr[0]), .wait_no(wt[0]),
    .legacy_iorq_no(liorq[0]));

  iack_sequencer #(.SYNC_EN(1'b1), .RD_TAP(RD_TAP), .WAIT_TAP(WAIT_TAP)) u_iack_sequencer_sync (
    .clk_i(clk), .rst_ni(rst_n), .m1_ni(m1_n), .mreq_ni(mreq_n), .iorq_ni(iorq_n),
    .sys_rd_ni(srd_n), .sys_wr_ni(swr_n), .sys_wait_ni(swait_n),
    .intack_no(intack[1]), .rd_no(rd[1]), .wr_no(wr[1]), .wait_no(wt[1]),
    .legacy_iorq_no(liorq[1]));

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int s = 0; s < 2; s++) begin
      int  e;
      logic ack, rdt, hold;
      e    = (s == 1) ? ((run > 0) ? run - 1 : 0) : run;
      ack  = (e >= 1);
      rdt  = (e >= RD_TAP + 1);
      hold = ack && (e < WAIT_TAP + 1);
      chk((s == 1) ? "R8" : "R3", "intack", intack[s], !ack);
      chk(rst_n ? "R4" : "R7", "rd", rd[s], rst_n & srd_n & !rdt);
      chk(rst_n ? "R6" : "R7", "wr", wr[s], rst_n & swr_n);
      chk("R5", "wait", wt[s], swait_n & !hold);
      chk("R9", "legacy_iorq", liorq[s], iorq_n | (!m1_n & !rdt));
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n)      run = 0;
    else if (m1_n)   run = 0;
    else if (mreq_n) run = run + 1;
    else             run = 0;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int a_idx, r_idx, w_idx;
    // reset state
    repeat (3) step();
    chk("R7", "rd in reset", rd[0], 1'b0);
    chk("R7", "wr in reset", wr[0], 1'b0);
    rst_n = 1'b1;
    step();
    // idle passthrough
    chk("R1", "intack idle", intack[0], 1'b1);
    srd_n = 1'b0; step(); chk("R6", "rd passthru", rd[0], 1'b0);
    swr_n = 1'b0; srd_n = 1'b1; step(); chk("R6", "wr passthru", wr[0], 1'b0);
    swr_n = 1'b1; swait_n = 1'b0; step(); chk("R6", "wait passthru", wt[0], 1'b0);
    swait_n = 1'b1; iorq_n = 1'b0; step(); chk("R1", "legacy idle", liorq[0], 1'b0);
    iorq_n = 1'b1; step();
    // opcode fetch
    m1_n = 1'b0; mreq_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2", "intack fetch", intack[0], 1'b1);
      chk("R2", "intack fetch sync", intack[1], 1'b1);
    end
    m1_n = 1'b1; mreq_n = 1'b1; step();
    // acknowledge cycle with timing measurement
    a_idx = -1; r_idx = -1; w_idx = -1;
    m1_n = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (i == 2) iorq_n = 1'b0;
      step();
      if (a_idx < 0 && !intack[0]) a_idx = i;
      if (r_idx < 0 && !rd[0]) r_idx = i;
      if (w_idx < 0 && a_idx >= 0 && wt[0]) w_idx = i;
    end
    chk("R4", "ack-to-rd clocks", (r_idx - a_idx) == RD_TAP, 1'b1);
    chk("R10", "ack-to-rd >= 350ns", (r_idx - a_idx) * CLK_PERIOD >= MIN_NS, 1'b1);
    chk("R10", "rd before release >= 350ns", (w_idx - r_idx) * CLK_PERIOD >= MIN_NS, 1'b1);
    m1_n = 1'b1; iorq_n = 1'b1; step();
    chk("R1", "intack cleared", intack[0], 1'b1);
    // fetch followed directly by acknowledge, with system wait also low
    m1_n = 1'b0; mreq_n = 1'b0; step(); step();
    mreq_n = 1'b1; swait_n = 1'b0;
    for (int i = 0; i < 4; i++) step();
    swait_n = 1'b1;
    for (int i = 0; i < 5; i++) step();
    m1_n = 1'b1; step();
    // plain I/O cycle
    iorq_n = 1'b0; srd_n = 1'b0; step(); step();
    chk("R9", "legacy io", liorq[0], 1'b0);
    iorq_n = 1'b1; srd_n = 1'b1; step();
    // reset in the middle of an acknowledge
    m1_n = 1'b0;
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b0; step();
    chk("R7", "intack after reset", intack[0], 1'b1);
    chk("R7", "rd in reset", rd[1], 1'b0);
    step();
    m1_n = 1'b1; step();
    rst_n = 1'b1; step(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule